// File: doc/BRIEF.md
# Lockable Clock Configuration Register Bank

This block keeps the settings for a reference clock generator and a PLL divider chain behind a small synchronous register port. Software first opens the bank by writing a 16-bit key to a lock register. It then stages new settings in pending registers. Those settings reach the clock hardware only when a soft-reset request arrives. At that point the pending words are copied into the active registers, and the active registers drive the generator's configuration outputs.

After a soft reset or a power-on reset, the block holds the system-reset output high for a minimum number of cycles. It then keeps that output high until the PLL lock input has been stable for a set number of consecutive cycles. This lets the downstream logic start only on settled clocks.

A second path exists for bring-up. A direct write to an active register changes the outputs at once, with no reset. Neither path checks whether a frequency is legal.

Top module: `clkcfg_bank`

## Requirements
- R1: While `por_n` is low, and on its release, the block is in its power-on state:
  - the pending and active oscillator words equal `OSC_DEFAULT` (0x00002C4A);
  - the pending and active PLL words equal `PLL_DEFAULT` (0x0B0101D0);
  - the bank is locked;
  - `sys_rst` is high.
- R2: The lock register at offset 0x020 works as follows:
  - writing 0xA05F into its low 16 bits unlocks the bank;
  - writing any other value locks it;
  - a read returns the last written 16-bit value in bits [15:0] and the locked flag (1 = locked) in bit 16, with zeros elsewhere.
- R3: The protected offsets are 0x07C (active PLL), 0x0D4 (active oscillator), 0x0DC (pending oscillator) and 0x100 (pending PLL).
  - A write to a protected offset while the bank is locked changes nothing and answers with `rsp_err`=1.
  - The same write while the bank is unlocked is accepted with `rsp_err`=0.
- R4: Writing a pending register leaves `osc_cfg` and the PLL field outputs unchanged.
- R5: A cycle with `soft_rst_req` high does two things:
  - it copies both pending words into the active registers, so they are visible on the outputs after that edge;
  - the pending registers keep their contents.
- R6: An accepted write to an active offset appears on the outputs after the capturing edge, and `sys_rst` is unaffected.
- R7: The active PLL word is split onto separate outputs:
  - `pll_adiv` is bits [31:24];
  - `pll_odiv` is bits [23:16];
  - `pll_fbdiv` is bits [11:4];
  - `pll_refdiv` is bits [3:0].
- R8: After a soft-reset cycle, `sys_rst` is high for at least `MIN_HOLD` (16) cycles, and then until `pll_lock` has been high on `LOCK_CYCLES` (4) consecutive edges.
  - With lock already steady, `sys_rst` falls on the 17th edge after the request edge.
  - A low lock sample restarts the consecutive count.
- R9: When a soft reset and a protected write fall in the same cycle:
  - the copy uses the pending value from before that write, while the pending register still takes the new value;
  - if the write targets an active register, the copy wins.
- R10: Reads of mapped offsets return their contents with `rsp_err`=0. Any access to an unmapped offset returns `rsp_rdata`=0 and `rsp_err`=1 and changes nothing. Writes return `rsp_rdata`=0.
- R11: Every request cycle produces `rsp_valid`=1 in the following cycle, together with its data and error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Rejected or unmapped access |
| soft_rst_req | input | 1 | Soft reset request, sampled each edge |
| pll_lock | input | 1 | Lock status from the PLL |
| osc_cfg | output | 32 | Active oscillator control word |
| pll_adiv | output | 8 | Active PLL field, bits [31:24] |
| pll_odiv | output | 8 | Active PLL field, bits [23:16] |
| pll_fbdiv | output | 8 | Active PLL field, bits [11:4] |
| pll_refdiv | output | 4 | Active PLL field, bits [3:0] |
| sys_rst | output | 1 | System reset, active high |

## Verification
Two functions can collide: a register write and a soft-reset copy landing on the same edge. The bench provokes this by raising `soft_rst_req` in the very cycle that carries a pending-PLL write, and again with a direct active-oscillator write. In the first case it judges the outcome from the outputs, which must show the earlier pending value, and from a readback of the pending register, which must show the new one. In the second case the outputs must show the pending oscillator word, not the directly written one.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 16;

  localparam logic [ADDR_W-1:0] OFS_LOCK     = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_ACT_PLL  = 12'h07C;
  localparam logic [ADDR_W-1:0] OFS_ACT_OSC  = 12'h0D4;
  localparam logic [ADDR_W-1:0] OFS_PEND_OSC = 12'h0DC;
  localparam logic [ADDR_W-1:0] OFS_PEND_PLL = 12'h100;

  typedef struct packed {
    logic [7:0] adiv;
    logic [7:0] odiv;
    logic [3:0] spare;
    logic [7:0] fbdiv;
    logic [3:0] refdiv;
  } pll_word_t;

  function automatic logic [DATA_W-1:0] lock_readback(input logic locked,
                                                      input logic [KEY_W-1:0] val);
    return {{(DATA_W-KEY_W-1){1'b0}}, locked, val};
  endfunction

  function automatic logic key_hit(input logic [DATA_W-1:0] wd,
                                   input logic [KEY_W-1:0] key);
    return wd[KEY_W-1:0] == key;
  endfunction

  function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
    return (a == OFS_ACT_PLL) || (a == OFS_ACT_OSC) ||
           (a == OFS_PEND_OSC) || (a == OFS_PEND_PLL);
  endfunction
endpackage

// File: rtl/clkcfg_keylock.sv
module clkcfg_keylock
  import clkcfg_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = 16'hA05F
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_lock,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic [KEY_W-1:0]  lock_val
);
  logic key_ok;
  assign key_ok = key_hit(wdata, KEY);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      locked   <= 1'b1;
      lock_val <= '0;
    end else if (wr_lock) begin
      locked   <= !key_ok;
      lock_val <= wdata[KEY_W-1:0];
    end
  end

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!por_n)
    (wr_lock && wdata[KEY_W-1:0] == KEY) |=> !locked); // R2
  AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!por_n)
    (wr_lock && wdata[KEY_W-1:0] != KEY) |=> locked); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    !wr_lock |=> $stable(locked)); // R2
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] OSC_DEFAULT = 32'h0000_2C4A,
  parameter logic [DATA_W-1:0] PLL_DEFAULT = 32'h0B01_01D0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_pend_osc,
  input  logic              wr_pend_pll,
  input  logic              wr_act_osc,
  input  logic              wr_act_pll,
  input  logic [DATA_W-1:0] wdata,
  input  logic              soft_go,
  output logic [DATA_W-1:0] pend_osc,
  output logic [DATA_W-1:0] pend_pll,
  output logic [DATA_W-1:0] act_osc,
  output logic [DATA_W-1:0] act_pll
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pend_osc <= OSC_DEFAULT;
      pend_pll <= PLL_DEFAULT;
    end else begin
      if (wr_pend_osc) pend_osc <= wdata;
      if (wr_pend_pll) pend_pll <= wdata;
    end
  end

  // copy uses pre-edge pending value and overrides a same-cycle direct write
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      act_osc <= OSC_DEFAULT;
      act_pll <= PLL_DEFAULT;
    end else if (soft_go) begin
      act_osc <= pend_osc;
      act_pll <= pend_pll;
    end else begin
      if (wr_act_osc) act_osc <= wdata;
      if (wr_act_pll) act_pll <= wdata;
    end
  end

  AST_COPY_PLL: assert property (@(posedge clk) disable iff (!por_n)
    soft_go |=> act_pll == $past(pend_pll)); // R5
  AST_COPY_OSC: assert property (@(posedge clk) disable iff (!por_n)
    soft_go |=> act_osc == $past(pend_osc)); // R9
  AST_ACT_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    (!soft_go && !wr_act_osc) |=> $stable(act_osc)); // R4
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!por_n)
    !wr_pend_pll |=> $stable(pend_pll)); // R5
endmodule

// File: rtl/clkcfg_rstseq.sv
module clkcfg_rstseq #(
  parameter int MIN_HOLD    = 16,
  parameter int LOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic soft_go,
  input  logic pll_lock,
  output logic sys_rst
);
  localparam int HW = $clog2(MIN_HOLD + 1);
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_END = HW'(MIN_HOLD);
  localparam logic [LW-1:0] LOCK_END = LW'(LOCK_CYCLES);

  logic [HW-1:0] hold_cnt;
  logic [LW-1:0] lk_cnt;
  logic          hold_done, lock_done;

  assign hold_done = (hold_cnt == HOLD_END);
  assign lock_done = (lk_cnt == LOCK_END);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_cnt <= '0;
      lk_cnt   <= '0;
      sys_rst  <= 1'b1;
    end else if (soft_go) begin
      hold_cnt <= '0;
      lk_cnt   <= '0;
      sys_rst  <= 1'b1;
    end else begin
      if (!hold_done) hold_cnt <= hold_cnt + 1'b1;
      if (!pll_lock) lk_cnt <= '0;
      else if (!lock_done) lk_cnt <= lk_cnt + 1'b1;
      if (hold_done && lock_done) sys_rst <= 1'b0;
    end
  end

  // independent observers for the checks
  localparam int SW = HW + 1;
  logic [SW-1:0] since_go;
  logic [LW:0]   lock_run;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      since_go <= '0;
      lock_run <= '0;
    end else begin
      if (soft_go) since_go <= '0;
      else if (since_go != '1) since_go <= since_go + 1'b1;
      if (!pll_lock) lock_run <= '0;
      else if (lock_run != '1) lock_run <= lock_run + 1'b1;
    end
  end

  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> (since_go > SW'(MIN_HOLD))); // R8
  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> (lock_run >= (LW+1)'(LOCK_CYCLES))); // R8
  AST_SOFT_ASSERTS: assert property (@(posedge clk) disable iff (!por_n)
    soft_go |=> sys_rst); // R8
endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
  import clkcfg_pkg::*;
#(
  parameter logic [15:0] KEY         = 16'hA05F,
  parameter logic [31:0] OSC_DEFAULT = 32'h0000_2C4A,
  parameter logic [31:0] PLL_DEFAULT = 32'h0B01_01D0,
  parameter int          MIN_HOLD    = 16,
  parameter int          LOCK_CYCLES = 4
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  input  logic        soft_rst_req,
  input  logic        pll_lock,
  output logic [31:0] osc_cfg,
  output logic [7:0]  pll_adiv,
  output logic [7:0]  pll_odiv,
  output logic [7:0]  pll_fbdiv,
  output logic [3:0]  pll_refdiv,
  output logic        sys_rst
);
  logic              locked;
  logic [KEY_W-1:0]  lock_val;
  logic [DATA_W-1:0] pend_osc, pend_pll, act_osc, act_pll;
  logic              wr_req, hit_lock, hit_guard, mapped, wr_ok;
  logic              wr_lock, wr_pend_osc, wr_pend_pll, wr_act_osc, wr_act_pll;
  logic              denied;
  logic [DATA_W-1:0] rd_mux;
  pll_word_t         pll_f;

  assign wr_req    = req_valid && req_write;
  assign hit_lock  = (req_addr == OFS_LOCK);
  assign hit_guard = is_guarded(req_addr);
  assign mapped    = hit_lock || hit_guard;
  assign wr_ok     = wr_req && hit_guard && !locked;
  assign denied    = req_valid && (!mapped || (req_write && hit_guard && locked));

  assign wr_lock     = wr_req && hit_lock;
  assign wr_pend_osc = wr_ok && (req_addr == OFS_PEND_OSC);
  assign wr_pend_pll = wr_ok && (req_addr == OFS_PEND_PLL);
  assign wr_act_osc  = wr_ok && (req_addr == OFS_ACT_OSC);
  assign wr_act_pll  = wr_ok && (req_addr == OFS_ACT_PLL);

  clkcfg_keylock #(.KEY(KEY)) u_lock (
    .clk(clk), .por_n(por_n), .wr_lock(wr_lock), .wdata(req_wdata),
    .locked(locked), .lock_val(lock_val)
  );

  clkcfg_regs #(.OSC_DEFAULT(OSC_DEFAULT), .PLL_DEFAULT(PLL_DEFAULT)) u_regs (
    .clk(clk), .por_n(por_n),
    .wr_pend_osc(wr_pend_osc), .wr_pend_pll(wr_pend_pll),
    .wr_act_osc(wr_act_osc), .wr_act_pll(wr_act_pll),
    .wdata(req_wdata), .soft_go(soft_rst_req),
    .pend_osc(pend_osc), .pend_pll(pend_pll),
    .act_osc(act_osc), .act_pll(act_pll)
  );

  clkcfg_rstseq #(.MIN_HOLD(MIN_HOLD), .LOCK_CYCLES(LOCK_CYCLES)) u_seq (
    .clk(clk), .por_n(por_n), .soft_go(soft_rst_req),
    .pll_lock(pll_lock), .sys_rst(sys_rst)
  );

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      unique case (req_addr)
        OFS_LOCK:     rd_mux = lock_readback(locked, lock_val);
        OFS_ACT_PLL:  rd_mux = act_pll;
        OFS_ACT_OSC:  rd_mux = act_osc;
        OFS_PEND_OSC: rd_mux = pend_osc;
        OFS_PEND_PLL: rd_mux = pend_pll;
        default:      rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_mux : '0;
      rsp_err   <= denied;
    end
  end

  assign pll_f      = pll_word_t'(act_pll);
  assign osc_cfg    = act_osc;
  assign pll_adiv   = pll_f.adiv;
  assign pll_odiv   = pll_f.odiv;
  assign pll_fbdiv  = pll_f.fbdiv;
  assign pll_refdiv = pll_f.refdiv;

  AST_LOCKED_WR_ERR: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid && req_write && hit_guard && locked) |=> rsp_err); // R3
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!por_n)
    req_valid |=> rsp_valid); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid && !mapped) |=> (rsp_err && rsp_rdata == '0)); // R10
  AST_LOCKED_NO_OSC: assert property (@(posedge clk) disable iff (!por_n)
    (locked && !soft_rst_req) |=> $stable(osc_cfg)); // R3
endmodule

// File: tb/clkcfg_bank_tb_top.sv
module clkcfg_bank_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        soft_rst_req = 1'b0, pll_lock = 1'b1;
  logic [31:0] osc_cfg;
  logic [7:0]  pll_adiv, pll_odiv, pll_fbdiv;
  logic [3:0]  pll_refdiv;
  logic        sys_rst;

  int total = 0, bad = 0;
  bit finished = 0;

  localparam logic [31:0] OSC_DEF = 32'h0000_2C4A;
  localparam logic [31:0] PLL_DEF = 32'h0B01_01D0;

  always #2.5 clk = ~clk;

  clkcfg_bank dut_i (
    .clk(clk), .por_n(por_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .soft_rst_req(soft_rst_req),
    .pll_lock(pll_lock), .osc_cfg(osc_cfg), .pll_adiv(pll_adiv),
    .pll_odiv(pll_odiv), .pll_fbdiv(pll_fbdiv), .pll_refdiv(pll_refdiv),
    .sys_rst(sys_rst)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] er;
    logic        ee;
  } vec_t;

  localparam vec_t VEC [0:11] = '{
    '{1'b0, 12'h020, 32'h0,          32'h0001_0000, 1'b0}, // R2 locked readback
    '{1'b1, 12'h0DC, 32'h0000_1234,  32'h0,         1'b1}, // R3 locked write
    '{1'b0, 12'h0DC, 32'h0,          OSC_DEF,       1'b0}, // R3 unchanged
    '{1'b1, 12'h020, 32'h0000_A05F,  32'h0,         1'b0}, // R2 key
    '{1'b0, 12'h020, 32'h0,          32'h0000_A05F, 1'b0}, // R2 open
    '{1'b1, 12'h0DC, 32'h0000_1234,  32'h0,         1'b0}, // R3 accepted
    '{1'b1, 12'h100, 32'h0405_01D0,  32'h0,         1'b0}, // R3 accepted
    '{1'b0, 12'h0DC, 32'h0,          32'h0000_1234, 1'b0}, // R10 read
    '{1'b0, 12'h0D4, 32'h0,          OSC_DEF,       1'b0}, // R4 active kept
    '{1'b0, 12'h07C, 32'h0,          PLL_DEF,       1'b0}, // R4 active kept
    '{1'b0, 12'h040, 32'h0,          32'h0,         1'b1}, // R10 unmapped read
    '{1'b1, 12'h040, 32'hFFFF_FFFF,  32'h0,         1'b1}  // R10 unmapped write
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic with_soft, output logic [31:0] rd, output logic er,
                      output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    soft_rst_req = with_soft;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; soft_rst_req = 1'b0;
    rd = rsp_rdata; er = rsp_err; vld = rsp_valid;
  endtask

  task automatic soft_pulse();
    @(negedge clk);
    soft_rst_req = 1'b1;
    @(negedge clk);
    soft_rst_req = 1'b0;
  endtask

  task automatic pll_word_chk(input string req, input logic [31:0] w);
    chk(req, {pll_adiv, pll_odiv, 4'h0, pll_fbdiv, pll_refdiv},
        {w[31:24], w[23:16], 4'h0, w[11:4], w[3:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic er, vld; int n;
    repeat (3) @(negedge clk);
    chk("R1 sys_rst in por", {31'b0, sys_rst}, 32'd1);
    chk("R1 osc default", osc_cfg, OSC_DEF);
    pll_word_chk("R1 pll default", PLL_DEF);
    por_n = 1'b1;
    repeat (25) @(negedge clk);
    chk("R8 release after por", {31'b0, sys_rst}, 32'd0);

    for (int i = 0; i < 12; i++) begin
      xfer(VEC[i].wr, VEC[i].addr, VEC[i].wd, 1'b0, rd, er, vld);
      chk($sformatf("R10 vec%0d data", i), rd, VEC[i].er);
      chk($sformatf("R3 vec%0d err", i), {31'b0, er}, {31'b0, VEC[i].ee});
      chk($sformatf("R11 vec%0d valid", i), {31'b0, vld}, 32'd1);
    end

    chk("R4 osc untouched", osc_cfg, OSC_DEF);
    pll_word_chk("R4 pll untouched", PLL_DEF);

    // soft reset with lock steady: count high samples
    @(negedge clk);
    soft_rst_req = 1'b1;
    @(negedge clk);
    soft_rst_req = 1'b0;
    chk("R5 osc copied", osc_cfg, 32'h0000_1234);
    pll_word_chk("R7 pll fields", 32'h0405_01D0);
    chk("R7 adiv", {24'b0, pll_adiv}, 32'h04);
    n = 0;
    while (sys_rst && n < 100) begin n++; @(negedge clk); end
    chk("R8 hold length", n, 32'd17);
    xfer(1'b0, 12'h0DC, 0, 1'b0, rd, er, vld);
    chk("R5 pending kept", rd, 32'h0000_1234);

    // lock gating
    pll_lock = 1'b0;
    soft_pulse();
    repeat (30) @(negedge clk);
    chk("R8 waits for lock", {31'b0, sys_rst}, 32'd1);
    pll_lock = 1'b1;
    repeat (2) @(negedge clk);
    pll_lock = 1'b0;
    @(negedge clk);
    pll_lock = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 still held after 4", {31'b0, sys_rst}, 32'd1);
    @(negedge clk);
    chk("R8 released after 5", {31'b0, sys_rst}, 32'd0);

    // direct active write
    xfer(1'b1, 12'h0D4, 32'h0000_BEEF, 1'b0, rd, er, vld);
    chk("R6 direct osc", osc_cfg, 32'h0000_BEEF);
    chk("R6 no reset", {31'b0, sys_rst}, 32'd0);
    xfer(1'b1, 12'h07C, 32'h0309_0270, 1'b0, rd, er, vld);
    pll_word_chk("R6 direct pll", 32'h0309_0270);

    // same-cycle collisions
    xfer(1'b1, 12'h100, 32'h0209_0270, 1'b1, rd, er, vld);
    pll_word_chk("R9 copy uses old pending", 32'h0405_01D0);
    xfer(1'b0, 12'h100, 0, 1'b0, rd, er, vld);
    chk("R9 pending took new", rd, 32'h0209_0270);
    xfer(1'b1, 12'h0D4, 32'h0000_5555, 1'b1, rd, er, vld);
    chk("R9 copy beats direct", osc_cfg, 32'h0000_1234);
    repeat (20) @(negedge clk);

    // relock
    xfer(1'b1, 12'h020, 32'h0000_0001, 1'b0, rd, er, vld);
    xfer(1'b0, 12'h020, 0, 1'b0, rd, er, vld);
    chk("R2 relock readback", rd, 32'h0001_0001);
    xfer(1'b1, 12'h0D4, 32'h0000_7777, 1'b0, rd, er, vld);
    chk("R3 relocked err", {31'b0, er}, 32'd1);
    chk("R3 relocked osc", osc_cfg, 32'h0000_1234);

    // power-on reset again
    xfer(1'b1, 12'h020, 32'h0000_A05F, 1'b0, rd, er, vld);
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    chk("R1 osc back", osc_cfg, OSC_DEF);
    chk("R1 sys_rst", {31'b0, sys_rst}, 32'd1);
    xfer(1'b0, 12'h0DC, 0, 1'b0, rd, er, vld);
    chk("R1 pending back", rd, OSC_DEF);
    xfer(1'b0, 12'h020, 0, 1'b0, rd, er, vld);
    chk("R1 locked again", rd, 32'h0001_0000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule